// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Arbiter

This block sits beside a small CPU core and decides which of eight level-sensitive interrupt request flags is handed to the core, and when. Each source has its own enable bit and its own priority bit, which selects between a low and a high level. A global enable bit gates every source at once. The controller tracks which priority levels are currently in service, so it can tell whether a new request may preempt the routine that is running.

Nesting goes two levels deep at most. A high-level request may preempt a low-level routine. Nothing preempts a high-level routine, and one low-level request cannot preempt another. A request is offered only when the core flags an instruction boundary. The offer is a one-cycle pulse carrying a vector index and the level taken. A return strobe from the core retires the innermost active level.

Configuration is written through a small port. A 2-bit selector picks one of four 8-bit registers, and all of them reset to zero. Sources 0..6 take their enable and priority bits from bits 0..6 of the two main registers. Source 7 takes its bits from bit 0 of the two extension registers. The global enable is bit 7 of the main enable register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all enable and priority bits are zero, no request is presented even with every source pending, and both in-service flags read 0.
- R2: While bit 7 of the main enable register (selector 0) is 0, no request is presented. Setting it lets enabled sources through.
- R3: Source i (i = 0..6) is enabled by bit i of register selector 0. Source 7 is enabled by bit 0 of register selector 1. A pending source whose enable bit is 0 is never presented.
- R4: Source i (i = 0..6) is made high level by bit i of register selector 2. Source 7 is made high level by bit 0 of register selector 3. A value of 1 means high and 0 means low, and `irq_hi_o` reports the level of the request taken.
- R5: Among eligible requests of the same level, the lowest source index wins (polling order 0 through 7), and its index appears on `irq_vec_o`.
- R6: When high-level and low-level requests are eligible together, a high-level one is taken.
- R7: A high-level request is taken while a low-level routine is in service (`isr_lo_o`=1, `isr_hi_o`=0).
- R8: No low-level request is taken while `isr_lo_o` is 1. No request at all is taken while `isr_hi_o` is 1.
- R9: A `reti_i` pulse clears `isr_hi_o` if it is set, and otherwise clears `isr_lo_o`. No request is taken in a cycle in which `reti_i` is high.
- R10: A request is taken only on a clock edge at which `insn_bnd_i` is 1. `irq_req_o` is high for exactly the one cycle after that edge, and then drops unless a new request is taken.
- R11: Taking a request sets the in-service flag of its level on the same edge on which `irq_req_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 main enable, 1 extension enable, 2 main priority, 3 extension priority |
| cfg_wdata_i | input | 8 | Configuration write data |
| src_pend_i | input | 8 | Level pending flags, bit i for source i |
| insn_bnd_i | input | 1 | Core is at an instruction boundary |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_o | output | 1 | One-cycle request pulse to the core |
| irq_vec_o | output | 3 | Index of the source taken |
| irq_hi_o | output | 1 | Level of the source taken (1 = high) |
| isr_hi_o | output | 1 | High-level routine in service |
| isr_lo_o | output | 1 | Low-level routine in service |

## Verification
A configuration write takes effect from the clock edge after the edge that captured it. A take is decided at the edge that samples `insn_bnd_i`, and `irq_req_o`, the vector, the level and the in-service flag all change on that same edge, so they are due one cycle after the stimulus. A return strobe changes the in-service flags on the edge that samples it. The bench drives every input just after a falling edge and reads every result at the following falling edge. Each check therefore lands exactly one register stage after its stimulus, away from the active edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_EN_MAIN = 2'd0,
    SEL_EN_EXT  = 2'd1,
    SEL_PR_MAIN = 2'd2,
    SEL_PR_EXT  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int N_SRC = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [DW-1:0]    wdata,
  output logic [N_SRC-1:0] src_en,
  output logic [N_SRC-1:0] src_hi,
  output logic             glob_en
);
  import irq_pkg::*;
  localparam int MAIN_SRC = DW - 1;
  localparam int EXT_SRC  = N_SRC - MAIN_SRC;

  logic [DW-1:0]       en_main_q;
  logic [EXT_SRC-1:0]  en_ext_q;
  logic [MAIN_SRC-1:0] pr_main_q;
  logic [EXT_SRC-1:0]  pr_ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_main_q <= '0;
      en_ext_q  <= '0;
      pr_main_q <= '0;
      pr_ext_q  <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_EN_MAIN: en_main_q <= wdata;
        SEL_EN_EXT:  en_ext_q  <= wdata[EXT_SRC-1:0];
        SEL_PR_MAIN: pr_main_q <= wdata[MAIN_SRC-1:0];
        default:     pr_ext_q  <= wdata[EXT_SRC-1:0];
      endcase
    end
  end

  assign src_en  = {en_ext_q, en_main_q[MAIN_SRC-1:0]};
  assign src_hi  = {pr_ext_q, pr_main_q};
  assign glob_en = en_main_q[DW-1];
endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1] = seen[g] | req[g];
    assign grant[g]  = req[g] & ~seen[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

  assign any = seen[N];
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track #(
  parameter int N_SRC = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bnd,
  input  logic          reti,
  input  logic          hi_any,
  input  logic [IW-1:0] hi_idx,
  input  logic          lo_any,
  input  logic [IW-1:0] lo_idx,
  output logic          req_o,
  output logic [IW-1:0] vec_o,
  output logic          lvl_o,
  output logic          isr_hi_q,
  output logic          isr_lo_q
);
  logic take_hi, take_lo;

  assign take_hi = bnd & ~reti & hi_any & ~isr_hi_q;
  assign take_lo = bnd & ~reti & ~hi_any & lo_any & ~isr_lo_q & ~isr_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o    <= 1'b0;
      vec_o    <= '0;
      lvl_o    <= 1'b0;
      isr_hi_q <= 1'b0;
      isr_lo_q <= 1'b0;
    end else begin
      req_o <= take_hi | take_lo;
      if (take_hi) begin
        vec_o <= hi_idx;
        lvl_o <= 1'b1;
      end else if (take_lo) begin
        vec_o <= lo_idx;
        lvl_o <= 1'b0;
      end
      if (reti) begin
        if (isr_hi_q) isr_hi_q <= 1'b0;
        else          isr_lo_q <= 1'b0;
      end
      if (take_hi) isr_hi_q <= 1'b1;
      if (take_lo) isr_lo_q <= 1'b1;
    end
  end

  AST_REQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(bnd) && !$past(reti)); // R10
  AST_HI_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    isr_hi_q |=> !req_o); // R8
  AST_TAKE_MARKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (lvl_o ? isr_hi_q : isr_lo_q)); // R11
  AST_RETI_RETIRES_HI: assert property (@(posedge clk) disable iff (rst)
    reti && isr_hi_q |=> !isr_hi_q && $stable(isr_lo_q)); // R9
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC = 8,
  parameter int DW    = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  input  logic [N_SRC-1:0] src_pend_i,
  input  logic             insn_bnd_i,
  input  logic             reti_i,
  output logic             irq_req_o,
  output logic [IW-1:0]    irq_vec_o,
  output logic             irq_hi_o,
  output logic             isr_hi_o,
  output logic             isr_lo_o
);
  logic [N_SRC-1:0] src_en, src_hi, live, hi_req, lo_req;
  logic             glob_en, hi_any, lo_any;
  logic [IW-1:0]    hi_idx, lo_idx;

  irq_cfg_regs #(.N_SRC(N_SRC), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we_i), .sel(cfg_sel_i), .wdata(cfg_wdata_i),
    .src_en(src_en), .src_hi(src_hi), .glob_en(glob_en)
  );

  assign live   = src_pend_i & src_en & {N_SRC{glob_en}};
  assign hi_req = live & src_hi;
  assign lo_req = live & ~src_hi;

  irq_first_pick #(.N(N_SRC)) u_pick_hi (.req(hi_req), .any(hi_any), .idx(hi_idx));
  irq_first_pick #(.N(N_SRC)) u_pick_lo (.req(lo_req), .any(lo_any), .idx(lo_idx));

  irq_nest_track #(.N_SRC(N_SRC)) u_nest (
    .clk(clk), .rst(rst), .bnd(insn_bnd_i), .reti(reti_i),
    .hi_any(hi_any), .hi_idx(hi_idx), .lo_any(lo_any), .lo_idx(lo_idx),
    .req_o(irq_req_o), .vec_o(irq_vec_o), .lvl_o(irq_hi_o),
    .isr_hi_q(isr_hi_o), .isr_lo_q(isr_lo_o)
  );

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> !irq_req_o); // R2
  AST_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
    hi_any && !isr_hi_o && insn_bnd_i && !reti_i |=> irq_req_o && irq_hi_o); // R6
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] pend = '0;
  logic       bnd = 1'b0;
  logic       reti = 1'b0;
  logic       req, hi, ihi, ilo;
  logic [2:0] vec;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .src_pend_i(pend), .insn_bnd_i(bnd), .reti_i(reti),
    .irq_req_o(req), .irq_vec_o(vec), .irq_hi_o(hi), .isr_hi_o(ihi), .isr_lo_o(ilo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pend = '0; bnd = 0; reti = 0; cfg_we = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input logic b, input logic r);
    bnd = b; reti = r;
    @(posedge clk); @(negedge clk);
    bnd = 1'b0; reti = 1'b0;
  endtask

  task automatic chk_take(input string tag, input int v, input int lvl);
    chk({tag, " req"}, int'(req), 1);
    chk({tag, " vec"}, int'(vec), v);
    chk({tag, " lvl"}, int'(hi), lvl);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req after reset", int'(req), 0);
    chk("R1 isr_hi after reset", int'(ihi), 0);
    chk("R1 isr_lo after reset", int'(ilo), 0);
    pend = 8'hFF;
    cyc(1, 0);
    chk("R1 zero config blocks", int'(req), 0);
  endtask

  task automatic t_global();
    do_reset();
    wr(2'd0, 8'h7F); wr(2'd1, 8'h01);
    pend = 8'hFF;
    cyc(1, 0);
    chk("R2 global off", int'(req), 0);
    wr(2'd0, 8'hFF);
    cyc(1, 0);
    chk_take("R2 global on", 0, 0);
  endtask

  task automatic t_enable();
    do_reset();
    wr(2'd0, 8'h80);
    pend = 8'h80;
    cyc(1, 0);
    chk("R3 source7 disabled", int'(req), 0);
    wr(2'd1, 8'h01);
    cyc(1, 0);
    chk_take("R3 source7 via ext reg", 7, 0);
    do_reset();
    wr(2'd0, 8'hA0);
    pend = 8'h24;
    cyc(1, 0);
    chk_take("R3 only source5 enabled", 5, 0);
  endtask

  task automatic t_order();
    do_reset();
    wr(2'd0, 8'hFF); wr(2'd1, 8'h01);
    pend = 8'h68;
    cyc(1, 0);
    chk_take("R5 lowest index wins", 3, 0);
    do_reset();
    wr(2'd0, 8'hFF); wr(2'd1, 8'h01);
    pend = 8'hC0;
    cyc(1, 0);
    chk_take("R5 six before seven", 6, 0);
  endtask

  task automatic t_prio();
    do_reset();
    wr(2'd0, 8'hFF); wr(2'd1, 8'h01); wr(2'd3, 8'h01);
    pend = 8'hFF;
    cyc(1, 0);
    chk_take("R4 R6 source7 high via ext prio", 7, 1);
    do_reset();
    wr(2'd0, 8'hFF); wr(2'd2, 8'h10);
    pend = 8'h11;
    cyc(1, 0);
    chk_take("R4 R6 source4 high over source0", 4, 1);
  endtask

  task automatic t_nesting();
    do_reset();
    wr(2'd0, 8'hFF); wr(2'd2, 8'h02);
    pend = 8'h01;
    cyc(1, 0);
    chk_take("R11 low taken", 0, 0);
    chk("R11 isr_lo set", int'(ilo), 1);
    chk("R11 isr_hi clear", int'(ihi), 0);
    pend = 8'h05;
    cyc(1, 0);
    chk("R8 low cannot preempt low", int'(req), 0);
    pend = 8'h07;
    cyc(1, 0);
    chk_take("R7 high preempts low", 1, 1);
    chk("R7 both levels active", int'(ihi & ilo), 1);
    cyc(1, 0);
    chk("R8 high service blocks all", int'(req), 0);
    pend = 8'h00;
    cyc(0, 1);
    chk("R9 reti clears hi", int'(ihi), 0);
    chk("R9 reti keeps lo", int'(ilo), 1);
    cyc(0, 1);
    chk("R9 second reti clears lo", int'(ilo), 0);
  endtask

  task automatic t_reti_block();
    do_reset();
    wr(2'd0, 8'hFF);
    pend = 8'h01;
    cyc(1, 1);
    chk("R9 no take on reti cycle", int'(req), 0);
    cyc(1, 0);
    chk_take("R9 take after reti", 0, 0);
  endtask

  task automatic t_boundary();
    do_reset();
    wr(2'd0, 8'hFF);
    pend = 8'h04;
    cyc(0, 0);
    chk("R10 no boundary no req", int'(req), 0);
    chk("R10 no boundary no isr", int'(ilo), 0);
    cyc(1, 0);
    chk_take("R10 boundary take", 2, 0);
    cyc(0, 0);
    chk("R10 single-cycle pulse", int'(req), 0);
  endtask

  initial begin
    t_reset();
    t_global();
    t_enable();
    t_order();
    t_prio();
    t_nesting();
    t_reti_block();
    t_boundary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule